// File: doc/BRIEF.md
# Correlating global-history branch direction predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register of the most recent resolved branch outcomes, the global history. It also keeps a table of small saturating up/down counters. A branch address does not own a single counter. It owns one counter for each possible history value, so the same branch can be predicted differently depending on how the branches just before it behaved. The table holds 2^HIST_W × 2^PC_IDX_W counters of CTR_W bits each, plus HIST_W bits of history.

Prediction is a purely combinational lookup from the fetch PC and the live history. The block also returns the history value it used, and the caller keeps that value with the branch. When the branch resolves, the caller presents the PC, the kept history and the real outcome on the update port. On that clock edge the one counter those values select is trained, and the outcome is shifted into the history. A parameter picks how PC bits and history are combined: they are placed side by side, or they are folded together with XOR into a smaller table.

Top module: `corr_bpred`

## Requirements
- R1: After reset the history is all zeros and every counter holds the weakly-not-taken value 2^(CTR_W-1)-1 (binary 01 for CTR_W=2), so every lookup predicts not taken.
- R2: Each update shifts its outcome into bit 0 of the history (1 = taken) and moves older outcomes one place up; `lk_hist` shows the register.
- R3: In a cycle without an update the history keeps its value.
- R4: In side-by-side mode the counter index is {history, PC[PC_LSB+PC_IDX_W-1:PC_LSB]}, with the history in the upper bits, so one PC reaches a different counter for each history value.
- R5: An update raises the selected counter by one on a taken outcome and lowers it by one on a not-taken outcome, holding at 2^CTR_W-1 and at 0.
- R6: The prediction is taken exactly when the selected counter is at least 2^(CTR_W-1).
- R7: An update changes no counter other than the one it selects.
- R8: The update indexes the table with the caller-supplied `up_hist`, not with the live history.
- R9: A lookup in the same cycle as an update to the same counter returns the value held before that update; the new value shows from the next cycle.
- R10: In folded mode the index is PC[PC_LSB+PC_IDX_W-1:PC_LSB] XOR the history zero-extended to PC_IDX_W bits.
- R11: PC bits outside the index field do not affect the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Prediction: 1 = taken |
| lk_hist | output | HIST_W | Live global history used for this lookup |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_hist | input | HIST_W | History kept from that branch's lookup |
| up_taken | input | 1 | Real outcome: 1 = taken |

## Verification
The table is trained through sequences of updates. Some repeat one (PC, history) pair until its counter saturates at either end. Some interleave unrelated branches so that the same PC is looked up under different live histories, which shows that history really selects the counter. Other updates carry a history that differs from the live one, which separates correct use of the caller's history from use of the live register. A lookup that coincides with an update shows the read-before-write order. PCs that differ only above the index field show the aliasing. A second instance in folded mode receives the same traffic. Its predictions differ from the side-by-side instance exactly where XOR folding merges entries.

// File: rtl/bp_pkg.sv
package bp_pkg;
   typedef enum logic {
      IDX_CONCAT = 1'b0,
      IDX_XOR    = 1'b1
   } idx_mode_e;
endpackage

// File: rtl/bp_hist.sv
module bp_hist #(
   parameter int HIST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist
);
   logic [HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] hist_d;

   generate
      if (HIST_W == 1) begin : g_one
         assign hist_d = shift_bit;
      end else begin : g_many
         assign hist_d = {hist_q[HIST_W-2:0], shift_bit};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist_q <= '0;
      else if (shift_en) hist_q <= hist_d;
   end

   assign hist = hist_q;
endmodule

// File: rtl/bp_index.sv
module bp_index import bp_pkg::*; #(
   parameter int        PC_W     = 16,
   parameter int        PC_LSB   = 2,
   parameter int        PC_IDX_W = 4,
   parameter int        HIST_W   = 2,
   parameter idx_mode_e IDX_MODE = IDX_CONCAT,
   parameter int        IDX_W    = PC_IDX_W + HIST_W
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  idx
);
   logic [PC_IDX_W-1:0] pc_field;
   assign pc_field = pc[PC_LSB +: PC_IDX_W];

   generate
      if (IDX_MODE == IDX_CONCAT) begin : g_concat
         assign idx = {hist, pc_field};
      end else begin : g_fold
         logic [PC_IDX_W-1:0] hist_ext;
         assign hist_ext = PC_IDX_W'(hist);
         assign idx      = pc_field ^ hist_ext;
      end
   endgenerate
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
   parameter int CTR_W = 2,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken,
   output logic [CTR_W-1:0] wr_old,
   output logic [CTR_W-1:0] wr_new
);
   localparam int             ENTRIES  = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_MAX  = '1;
   localparam logic [CTR_W-1:0] CTR_ZERO = '0;
   localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W-1)) - 1);

   logic [CTR_W-1:0] ctr [ENTRIES];

   assign wr_old = ctr[wr_idx];

   always_comb begin
      wr_new = wr_old;
      if (wr_taken) begin
         if (wr_old != CTR_MAX) wr_new = wr_old + 1'b1;
      end else begin
         if (wr_old != CTR_ZERO) wr_new = wr_old - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ctr[i] <= CTR_INIT;
      end else if (wr_en) begin
         ctr[wr_idx] <= wr_new;
      end
   end

   // upper half of the counter range means taken
   assign rd_taken = ctr[rd_idx][CTR_W-1];
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred import bp_pkg::*; #(
   parameter int        PC_W     = 16,
   parameter int        PC_LSB   = 2,
   parameter int        PC_IDX_W = 4,
   parameter int        HIST_W   = 2,
   parameter int        CTR_W    = 2,
   parameter idx_mode_e IDX_MODE = IDX_CONCAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   lk_pc,
   output logic              lk_taken,
   output logic [HIST_W-1:0] lk_hist,
   input  logic              up_valid,
   input  logic [PC_W-1:0]   up_pc,
   input  logic [HIST_W-1:0] up_hist,
   input  logic              up_taken
);
   localparam int IDX_W = (IDX_MODE == IDX_CONCAT) ? (PC_IDX_W + HIST_W) : PC_IDX_W;

   generate
      if (HIST_W < 1) begin : g_bad_hist
         $error("HIST_W must be at least 1");
      end
      if (CTR_W < 1) begin : g_bad_ctr
         $error("CTR_W must be at least 1");
      end
      if (PC_LSB + PC_IDX_W > PC_W) begin : g_bad_pc
         $error("index field lies outside the PC");
      end
      if (IDX_MODE == IDX_XOR && HIST_W > PC_IDX_W) begin : g_bad_fold
         $error("folded mode needs HIST_W <= PC_IDX_W");
      end
      if (IDX_W > 12) begin : g_bad_size
         $error("table index wider than 12 bits");
      end
   endgenerate

   logic [HIST_W-1:0] ghr;
   logic [IDX_W-1:0]  rd_idx;
   logic [IDX_W-1:0]  wr_idx;
   logic [CTR_W-1:0]  wr_old;
   logic [CTR_W-1:0]  wr_new;

   bp_hist #(.HIST_W(HIST_W)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (up_valid),
      .shift_bit (up_taken),
      .hist      (ghr)
   );

   bp_index #(
      .PC_W(PC_W), .PC_LSB(PC_LSB), .PC_IDX_W(PC_IDX_W),
      .HIST_W(HIST_W), .IDX_MODE(IDX_MODE), .IDX_W(IDX_W)
   ) u_rd_ix (
      .pc   (lk_pc),
      .hist (ghr),
      .idx  (rd_idx)
   );

   bp_index #(
      .PC_W(PC_W), .PC_LSB(PC_LSB), .PC_IDX_W(PC_IDX_W),
      .HIST_W(HIST_W), .IDX_MODE(IDX_MODE), .IDX_W(IDX_W)
   ) u_wr_ix (
      .pc   (up_pc),
      .hist (up_hist),
      .idx  (wr_idx)
   );

   bp_ctr_table #(.CTR_W(CTR_W), .IDX_W(IDX_W)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (rd_idx),
      .rd_taken (lk_taken),
      .wr_en    (up_valid),
      .wr_idx   (wr_idx),
      .wr_taken (up_taken),
      .wr_old   (wr_old),
      .wr_new   (wr_new)
   );

   assign lk_hist = ghr;
endmodule

// File: rtl/bp_chk.sv
module bp_chk #(
   parameter int HIST_W = 2,
   parameter int CTR_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              up_valid,
   input logic              up_taken,
   input logic [HIST_W-1:0] lk_hist,
   input logic [CTR_W-1:0]  wr_old,
   input logic [CTR_W-1:0]  wr_new
);
   localparam logic [CTR_W-1:0] CTR_MAX = '1;

   // R1
   hist_reset_chk: assert property (@(posedge clk) !rst_n |=> lk_hist == '0);

   // R2
   hist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |=> lk_hist[0] == $past(up_taken));

   generate
      if (HIST_W > 1) begin : g_age
         // R2
         hist_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
            up_valid |=> lk_hist[HIST_W-1:1] == $past(lk_hist[HIST_W-2:0]));
      end
   endgenerate

   // R3
   hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> $stable(lk_hist));

   // R5
   ctr_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken && wr_old == CTR_MAX) |-> wr_new == CTR_MAX);

   // R5
   ctr_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken && wr_old == '0) |-> wr_new == '0);

   // R5
   ctr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> (up_taken ? (wr_new >= wr_old) : (wr_new <= wr_old)));
endmodule

bind corr_bpred bp_chk #(.HIST_W(HIST_W), .CTR_W(CTR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .up_valid (up_valid),
   .up_taken (up_taken),
   .lk_hist  (lk_hist),
   .wr_old   (wr_old),
   .wr_new   (wr_new)
);

// File: tb/sim_corr_bpred.sv
module sim_corr_bpred;
   import bp_pkg::*;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic       e0;
      logic       e1;
      logic [1:0] eh;
      string      req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] lk_pc = '0;
   logic        up_valid = 1'b0;
   logic [15:0] up_pc = '0;
   logic [1:0]  up_hist = '0;
   logic        up_taken = 1'b0;
   logic        p0, p1;
   logic [1:0]  h0, h1;

   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 0;
   exp_t q[$];
   event ev_look;

   // independent model
   int         m0 [64];
   int         m1 [16];
   logic [1:0] mh;

   always #(CLK_PERIOD/2) clk = ~clk;

   corr_bpred #(.IDX_MODE(IDX_CONCAT)) u0 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p0), .lk_hist(h0),
      .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken));

   corr_bpred #(.IDX_MODE(IDX_XOR)) u1 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p1), .lk_hist(h1),
      .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken));

   function automatic int cix(logic [15:0] pc, logic [1:0] h);
      return {h, pc[5:2]};
   endfunction

   function automatic int gix(logic [15:0] pc, logic [1:0] h);
      return pc[5:2] ^ {2'b00, h};
   endfunction

   function automatic int bump(int v, logic t);
      if (t) return (v < 3) ? v + 1 : 3;
      return (v > 0) ? v - 1 : 0;
   endfunction

   task automatic push_exp(logic [15:0] pc, string req);
      exp_t e;
      e.e0  = (m0[cix(pc, mh)] >= 2);
      e.e1  = (m1[gix(pc, mh)] >= 2);
      e.eh  = mh;
      e.req = req;
      q.push_back(e);
   endtask

   task automatic model_upd(logic [15:0] pc, logic [1:0] h, logic t);
      m0[cix(pc, h)] = bump(m0[cix(pc, h)], t);
      m1[gix(pc, h)] = bump(m1[gix(pc, h)], t);
      mh = {mh[0], t};
   endtask

   task automatic look(logic [15:0] pc, string req);
      @(negedge clk);
      lk_pc = pc;
      push_exp(pc, req);
      -> ev_look;
      #2;
   endtask

   task automatic upd(logic [15:0] pc, logic [1:0] h, logic t);
      @(negedge clk);
      up_valid = 1'b1; up_pc = pc; up_hist = h; up_taken = t;
      @(posedge clk);
      model_upd(pc, h, t);
      #1 up_valid = 1'b0;
   endtask

   task automatic upd_and_look(logic [15:0] pc, logic [1:0] h, logic t, string req);
      @(negedge clk);
      up_valid = 1'b1; up_pc = pc; up_hist = h; up_taken = t;
      lk_pc = pc;
      push_exp(pc, req);
      -> ev_look;
      @(posedge clk);
      model_upd(pc, h, t);
      #1 up_valid = 1'b0;
   endtask

   // monitor: compare each expected item with what the design shows
   initial begin
      forever begin
         @(ev_look);
         #1;
         if (q.size() == 0) begin
            n_run++; n_fail++;
            $display("FAIL scoreboard empty on lookup actual=0 expected=1");
         end else begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (p0 !== e.e0) begin
               n_fail++;
               $display("FAIL %s u0 prediction pc=%h actual=%b expected=%b", e.req, lk_pc, p0, e.e0);
            end
            n_run++;
            if (p1 !== e.e1) begin
               n_fail++;
               $display("FAIL %s R10 u1 prediction pc=%h actual=%b expected=%b", e.req, lk_pc, p1, e.e1);
            end
            n_run++;
            if (h0 !== e.eh) begin
               n_fail++;
               $display("FAIL %s history actual=%b expected=%b", e.req, h0, e.eh);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) m0[i] = 1;
      for (int i = 0; i < 16; i++) m1[i] = 1;
      mh = 2'b00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      look(16'h0000, "R1");
      look(16'h0010, "R1");
      look(16'hFFFC, "R1");

      // R2, R4: train under history 00, look under history 01
      upd(16'h0010, 2'b00, 1'b1);
      look(16'h0010, "R4 R2");
      upd(16'h0010, 2'b01, 1'b1);
      look(16'h0010, "R4 R2");

      // R3: no update, history holds
      look(16'h0010, "R3");
      look(16'h0020, "R3");

      // R6: back to history 00, trained entry predicts taken
      upd(16'h0020, 2'b11, 1'b0);
      upd(16'h0020, 2'b11, 1'b0);
      look(16'h0010, "R6");
      // R11: upper PC bits ignored
      look(16'h8010, "R11");
      look(16'hF310, "R11");
      // R7: neighbouring entry untouched in u0, folded in u1
      look(16'h0014, "R7");
      look(16'h0018, "R7");

      // R8: update history differs from live history
      upd(16'h0030, 2'b10, 1'b1);
      upd(16'h0020, 2'b11, 1'b0);
      look(16'h0030, "R8");
      look(16'h0034, "R8");

      // R5: saturate high, one not-taken keeps taken
      repeat (5) upd(16'h0040, 2'b01, 1'b1);
      upd(16'h0040, 2'b01, 1'b0);
      upd(16'h003C, 2'b00, 1'b0);
      upd(16'h003C, 2'b00, 1'b1);
      look(16'h0040, "R5");

      // R5: saturate low, one taken keeps not-taken
      repeat (5) upd(16'h0044, 2'b00, 1'b0);
      upd(16'h0044, 2'b00, 1'b1);
      upd(16'h003C, 2'b11, 1'b0);
      upd(16'h003C, 2'b11, 1'b0);
      look(16'h0044, "R5");

      // R9: lookup during update returns old value
      upd_and_look(16'h0044, 2'b00, 1'b1, "R9");
      upd(16'h003C, 2'b01, 1'b0);
      upd(16'h003C, 2'b10, 1'b0);
      look(16'h0044, "R9");

      // R10: folded mode under a nonzero history
      upd(16'h0004, 2'b00, 1'b1);
      look(16'h0000, "R10");
      look(16'h0004, "R10");

      #(CLK_PERIOD * 2);
      n_run++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard leftover items actual=%0d expected=0", q.size());
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule